// File: doc/BRIEF.md
# Simulation Finisher Peripheral

This block is a small register slave that lets software on a processor end a simulation run or request a system reset by writing a single command word. It decodes a 4 KiB address window. One offset, zero, holds the command register. A write there is split into two halves: the low half selects an action and the high half carries an exit code. The block turns each recognised action into a one-cycle pulse for the surrounding test harness. The exit code that goes with a termination is held on a separate output.

The register is write-only, and every read returns zero. A write that the block cannot act on is not dropped without notice. It raises a one-cycle error-log pulse, together with the address and the data that caused it, so the harness can report it. The request interface uses a plain valid/ready handshake. Ready is always high, and a response is returned exactly one cycle after each accepted request.

Top module: `sim_finisher`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output except req_ready is zero. This covers exit_code, err_log_addr and err_log_data. An exit code latched before a reset is cleared by that reset.
- R2: req_ready is high out of reset. Every cycle with req_valid high accepts a request, and rsp_valid is high on exactly the following cycle.
- R3: A read at any offset, of a legal size, answers rsp_rdata = 0 with rsp_err low. It raises no command pulse and no error-log pulse.
- R4: req_size encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Only sizes 1 and 2 are legal. Any other size, for a read or a write, answers rsp_err high and raises no command pulse and no error-log pulse.
- R5: A legal write to offset 0 with bits 15:0 equal to 16'h3333 pulses fail_pulse for one cycle. On that cycle exit_code equals bits 31:16 of the write data.
- R6: A legal write to offset 0 with bits 15:0 equal to 16'h5555 pulses pass_pulse for one cycle, with exit_code equal to 0.
- R7: A legal write to offset 0 with bits 15:0 equal to 16'h7777 pulses reset_req_pulse for one cycle. It pulses neither pass_pulse nor fail_pulse and leaves exit_code unchanged.
- R8: A legal write to offset 0 whose low half matches none of the three encodings pulses err_log_pulse for one cycle. It raises no command pulse. err_log_addr shows the offset and err_log_data shows the write data.
- R9: A legal write to any nonzero offset pulses err_log_pulse with that offset and the write data, and raises no command pulse.
- R10: A 2-byte write uses only bits 15:0 of req_wdata, and the upper half is taken as zero. A 2-byte fail write therefore gives exit code 0, and a logged 2-byte write reports data with bits 31:16 cleared.
- R11: exit_code keeps its value on every cycle that has no pass_pulse and no fail_pulse.
- R12: All response and event outputs appear on the cycle after the request is accepted. At most one of pass_pulse, fail_pulse, reset_req_pulse and err_log_pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset within the window |
| req_size | input | 2 | Access width code |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (always zero) |
| rsp_err | output | 1 | Illegal access size |
| pass_pulse | output | 1 | Pass termination event |
| fail_pulse | output | 1 | Fail termination event |
| reset_req_pulse | output | 1 | System reset request |
| exit_code | output | 16 | Latched exit code |
| err_log_pulse | output | 1 | Unrecognised write event |
| err_log_addr | output | ADDR_W (12) | Offset of the logged write |
| err_log_data | output | 32 | Data of the logged write |

## Verification
The assertions assume that req_valid stays low while reset is held. This lets the one-cycle-back checks on the address, the data and the acceptance strobe start from a known quiet request. They also assume that req_size is always one of the four codes, with no unknown values. The stimulus meets both assumptions: it drives requests only after reset is released, changes inputs only on the falling clock edge, and drops req_valid before it asserts reset in mid-run.

// File: rtl/sim_finisher_pkg.sv
package sim_finisher_pkg;

  localparam int unsigned FIN_DATA_W = 32;
  localparam int unsigned FIN_HALF_W = FIN_DATA_W / 2;

  localparam logic [FIN_HALF_W-1:0] ST_FAIL  = 16'h3333;
  localparam logic [FIN_HALF_W-1:0] ST_PASS  = 16'h5555;
  localparam logic [FIN_HALF_W-1:0] ST_RESET = 16'h7777;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_PASS  = 3'd1,
    CMD_FAIL  = 3'd2,
    CMD_RESET = 3'd3,
    CMD_LOG   = 3'd4
  } fin_cmd_e;

  // Only half-word and word accesses are accepted.
  function automatic logic size_legal(input logic [1:0] sz);
    return (sz == SZ_HALF) || (sz == SZ_WORD);
  endfunction

  // A half-word access carries only the low lanes; the upper lanes read as zero.
  function automatic logic [FIN_DATA_W-1:0] lane_data(input logic [1:0] sz,
                                                      input logic [FIN_DATA_W-1:0] d);
    if (sz == SZ_HALF) return {{FIN_HALF_W{1'b0}}, d[FIN_HALF_W-1:0]};
    return d;
  endfunction

  // Map a legal write to the action it requests.
  function automatic fin_cmd_e classify(input logic at_cmd,
                                        input logic [FIN_HALF_W-1:0] st);
    if (!at_cmd) return CMD_LOG;
    case (st)
      ST_FAIL:  return CMD_FAIL;
      ST_PASS:  return CMD_PASS;
      ST_RESET: return CMD_RESET;
      default:  return CMD_LOG;
    endcase
  endfunction

endpackage

// File: rtl/fin_access_gate.sv
module fin_access_gate
  import sim_finisher_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                  valid_in,
  input  logic                  write_in,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic [1:0]            size_in,
  input  logic [FIN_DATA_W-1:0] wdata_in,
  output logic                  acc_fire,
  output logic                  acc_bad_size,
  output logic                  wr_ok,
  output logic                  at_cmd_reg,
  output logic [FIN_DATA_W-1:0] wdata_eff
);

  logic legal;

  assign legal        = size_legal(size_in);
  assign acc_fire     = valid_in;
  assign acc_bad_size = valid_in && !legal;
  assign wr_ok        = valid_in && write_in && legal;
  assign at_cmd_reg   = (addr_in == '0);
  assign wdata_eff    = lane_data(size_in, wdata_in);

endmodule

// File: rtl/fin_cmd_decode.sv
module fin_cmd_decode
  import sim_finisher_pkg::*;
(
  input  logic                  wr_ok,
  input  logic                  at_cmd_reg,
  input  logic [FIN_DATA_W-1:0] wdata_eff,
  output fin_cmd_e              cmd,
  output logic [FIN_HALF_W-1:0] code
);

  logic [FIN_HALF_W-1:0] status;

  assign status = wdata_eff[FIN_HALF_W-1:0];
  assign code   = wdata_eff[FIN_DATA_W-1:FIN_HALF_W];
  assign cmd    = wr_ok ? classify(at_cmd_reg, status) : CMD_NONE;

endmodule

// File: rtl/fin_event_regs.sv
module fin_event_regs
  import sim_finisher_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_fire,
  input  logic                  acc_bad_size,
  input  fin_cmd_e              cmd,
  input  logic [FIN_HALF_W-1:0] code_in,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic [FIN_DATA_W-1:0] wdata_in,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic                  pass_pulse,
  output logic                  fail_pulse,
  output logic                  reset_req_pulse,
  output logic [FIN_HALF_W-1:0] exit_code,
  output logic                  err_log_pulse,
  output logic [ADDR_W-1:0]     err_log_addr,
  output logic [FIN_DATA_W-1:0] err_log_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_err         <= 1'b0;
      pass_pulse      <= 1'b0;
      fail_pulse      <= 1'b0;
      reset_req_pulse <= 1'b0;
      err_log_pulse   <= 1'b0;
      exit_code       <= '0;
      err_log_addr    <= '0;
      err_log_data    <= '0;
    end else begin
      rsp_valid       <= acc_fire;
      rsp_err         <= acc_bad_size;
      pass_pulse      <= (cmd == CMD_PASS);
      fail_pulse      <= (cmd == CMD_FAIL);
      reset_req_pulse <= (cmd == CMD_RESET);
      err_log_pulse   <= (cmd == CMD_LOG);
      if (cmd == CMD_FAIL)      exit_code <= code_in;
      else if (cmd == CMD_PASS) exit_code <= '0;
      if (cmd == CMD_LOG) begin
        err_log_addr <= addr_in;
        err_log_data <= wdata_in;
      end
    end
  end

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_fire));

  // R4
  bad_size_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !(pass_pulse || fail_pulse || reset_req_pulse || err_log_pulse));

  // R5
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |-> exit_code == $past(wdata_in[FIN_DATA_W-1:FIN_HALF_W]));

  // R6
  pass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |-> exit_code == '0);

  // R9
  log_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_log_pulse |-> err_log_addr == $past(addr_in));

  // R11
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_pulse || fail_pulse) |-> $stable(exit_code));

  // R12
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_pulse, fail_pulse, reset_req_pulse, err_log_pulse}));

endmodule

// File: rtl/sim_finisher.sv
module sim_finisher
  import sim_finisher_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_size,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata,
  output logic                  rsp_err,
  output logic                  pass_pulse,
  output logic                  fail_pulse,
  output logic                  reset_req_pulse,
  output logic [15:0]           exit_code,
  output logic                  err_log_pulse,
  output logic [ADDR_W-1:0]     err_log_addr,
  output logic [31:0]           err_log_data
);

  logic                  acc_fire;
  logic                  acc_bad_size;
  logic                  wr_ok;
  logic                  at_cmd_reg;
  logic [FIN_DATA_W-1:0] wdata_eff;
  fin_cmd_e              cmd;
  logic [FIN_HALF_W-1:0] code;

  assign req_ready = 1'b1;
  assign rsp_rdata = '0;

  fin_access_gate #(.ADDR_W(ADDR_W)) u_gate (
    .valid_in     (req_valid),
    .write_in     (req_write),
    .addr_in      (req_addr),
    .size_in      (req_size),
    .wdata_in     (req_wdata),
    .acc_fire     (acc_fire),
    .acc_bad_size (acc_bad_size),
    .wr_ok        (wr_ok),
    .at_cmd_reg   (at_cmd_reg),
    .wdata_eff    (wdata_eff)
  );

  fin_cmd_decode u_dec (
    .wr_ok      (wr_ok),
    .at_cmd_reg (at_cmd_reg),
    .wdata_eff  (wdata_eff),
    .cmd        (cmd),
    .code       (code)
  );

  fin_event_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_fire        (acc_fire),
    .acc_bad_size    (acc_bad_size),
    .cmd             (cmd),
    .code_in         (code),
    .addr_in         (req_addr),
    .wdata_in        (wdata_eff),
    .rsp_valid       (rsp_valid),
    .rsp_err         (rsp_err),
    .pass_pulse      (pass_pulse),
    .fail_pulse      (fail_pulse),
    .reset_req_pulse (reset_req_pulse),
    .exit_code       (exit_code),
    .err_log_pulse   (err_log_pulse),
    .err_log_addr    (err_log_addr),
    .err_log_data    (err_log_data)
  );

  // R3
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata == '0 && req_ready);

endmodule

// File: tb/sim_finisher_test.sv
`timescale 1ns/1ps
module sim_finisher_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        pass_pulse, fail_pulse, reset_req_pulse, err_log_pulse;
  logic [15:0] exit_code;
  logic [11:0] err_log_addr;
  logic [31:0] err_log_data;

  int tests = 0;
  int fails = 0;

  // reference state
  int unsigned m_exit = 0;
  int unsigned m_laddr = 0;
  int unsigned m_ldata = 0;

  always #2.5 clk = ~clk;

  sim_finisher uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .pass_pulse(pass_pulse), .fail_pulse(fail_pulse),
    .reset_req_pulse(reset_req_pulse), .exit_code(exit_code),
    .err_log_pulse(err_log_pulse), .err_log_addr(err_log_addr),
    .err_log_data(err_log_data)
  );

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle of request (or idle), then compare every output.
  task automatic step(input string tag, input bit v, input bit w,
                      input int unsigned a, input int unsigned sz,
                      input int unsigned d);
    bit legal;
    int unsigned eff;
    bit e_pass, e_fail, e_rst, e_log;
    legal = (sz == 1) || (sz == 2);
    eff = (sz == 1) ? (d & 32'h0000_FFFF) : d;
    e_pass = 0; e_fail = 0; e_rst = 0; e_log = 0;
    if (v && w && legal) begin
      if (a != 0) e_log = 1;
      else if ((eff & 16'hFFFF) == 16'h3333) e_fail = 1;
      else if ((eff & 16'hFFFF) == 16'h5555) e_pass = 1;
      else if ((eff & 16'hFFFF) == 16'h7777) e_rst = 1;
      else e_log = 1;
    end
    if (e_fail) m_exit = eff >> 16;
    if (e_pass) m_exit = 0;
    if (e_log) begin m_laddr = a; m_ldata = eff; end
    req_valid = v; req_write = w; req_addr = a[11:0];
    req_size = sz[1:0]; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(tag, "req_ready", req_ready, 1);
    check(tag, "rsp_valid", rsp_valid, v);
    check(tag, "rsp_err", rsp_err, v && !legal);
    check(tag, "rsp_rdata", rsp_rdata, 0);
    check(tag, "pass_pulse", pass_pulse, e_pass);
    check(tag, "fail_pulse", fail_pulse, e_fail);
    check(tag, "reset_req_pulse", reset_req_pulse, e_rst);
    check(tag, "err_log_pulse", err_log_pulse, e_log);
    check(tag, "exit_code", exit_code, m_exit);
    if (e_log) begin
      check(tag, "err_log_addr", err_log_addr, m_laddr);
      check(tag, "err_log_data", err_log_data, m_ldata);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check(tag, "rsp_valid", rsp_valid, 0);
    check(tag, "rsp_err", rsp_err, 0);
    check(tag, "pulses", {pass_pulse, fail_pulse, reset_req_pulse, err_log_pulse}, 0);
    check(tag, "exit_code", exit_code, 0);
    check(tag, "err_log_addr", err_log_addr, 0);
    check(tag, "err_log_data", err_log_data, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1");

    step("R2", 0, 0, 0, 2, 0);
    // R3 reads return zero, no events
    step("R3", 1, 0, 0, 2, 32'h1234_3333);
    step("R3", 1, 0, 12'h7FC, 1, 0);
    // R5 fail with code
    step("R5", 1, 1, 0, 2, 32'hBEEF_3333);
    // R11 idle and read hold the code
    step("R11", 0, 0, 0, 2, 0);
    step("R11", 1, 0, 12'h004, 2, 0);
    // R7 reset request keeps exit code
    step("R7", 1, 1, 0, 2, 32'hAAAA_7777);
    // R8 unrecognised status
    step("R8", 1, 1, 0, 2, 32'h0001_3334);
    // R9 nonzero offset, including one that holds a valid status
    step("R9", 1, 1, 12'h004, 2, 32'h0000_5555);
    step("R9", 1, 1, 12'hFFE, 1, 32'hFFFF_1234);
    // R4 illegal sizes, writes and reads
    step("R4", 1, 1, 0, 0, 32'h0000_5555);
    step("R4", 1, 1, 0, 3, 32'h0042_3333);
    step("R4", 1, 0, 0, 3, 0);
    // R6 pass clears code
    step("R6", 1, 1, 0, 2, 32'h7777_5555);
    // R10 half-word fail drops upper lanes
    step("R5", 1, 1, 0, 2, 32'h0101_3333);
    step("R10", 1, 1, 0, 1, 32'hCAFE_3333);
    step("R10", 1, 1, 0, 1, 32'hDEAD_9999);
    // R12 back-to-back commands
    step("R12", 1, 1, 0, 2, 32'h0007_3333);
    step("R12", 1, 1, 0, 2, 32'h0000_7777);
    step("R12", 1, 1, 0, 2, 32'h0000_5555);
    step("R12", 1, 1, 0, 2, 32'h0055_3333);

    // R1 reset in mid-run clears the latched code
    req_valid = 0;
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    m_exit = 0; m_laddr = 0; m_ldata = 0;
    @(negedge clk);
    check_reset_state("R1");
    step("R11", 0, 0, 0, 2, 0);
    step("R7", 1, 1, 0, 1, 32'h0000_7777);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule